// File: doc/BRIEF.md
# Keyboard Scan Code Set 2 Decoder

This block sits behind a keyboard serial receiver. It takes one received byte at a time, each marked by a one-cycle valid strobe, and folds the multi-byte sequences of scan code set 2 into single key events. Each event carries:

- the base code of the key,
- a flag for keys sent with the E0h prefix,
- a flag for key releases,
- a one-cycle valid pulse.

Keyboard response bytes are reported on a separate status channel and never appear as keys. The block does not translate codes to characters. It adds no repeat timing of its own: a held key repeats because the keyboard resends its make code, and each repeated make code gives an ordinary press event.

Print screen and pause each reach the host as one event. The print screen make and break sequences each become a single extended event with base code 7Ch. The pause sequence becomes a single press event with base code E1h, which no other key uses. Any byte that does not fit the sequence in progress is dropped, and decoding starts again from the idle state.

The parameter `PRT_MERGE` chooses how print screen is handled. With `PRT_MERGE` = 1 (the default), each print screen sequence is merged into one event. With `PRT_MERGE` = 0, its bytes are decoded as ordinary extended codes. The requirements below assume the default.

Top module: `kbd_sc2_decoder`

## Requirements
- R1: In the idle state, a byte that is not E0h, F0h, E1h or a response code produces a press event one clock after the edge that accepts it. The event has that byte as its code, extended = 0 and release = 0, and its valid is high for exactly one cycle.
- R2: F0h followed by a code byte gives one release event: that code, release = 1, extended = 0. F0h alone gives no event.
- R3: E0h followed by a code byte gives an extended press. E0h, F0h and a code byte give an extended release. The prefixes alone give no event.
- R4: The bytes E0 12 E0 7C give exactly one event: code 7Ch, extended = 1, release = 0.
- R5: The bytes E0 F0 7C E0 F0 12 give exactly one event: code 7Ch, extended = 1, release = 1.
- R6: The eight bytes E1 14 77 E1 F0 14 F0 77 give exactly one event, after the last byte: code E1h, extended = 0, release = 0. No release event is ever produced for it.
- R7: In the idle state, a response byte produces a one-cycle status pulse and no key event. The status kind is encoded as: AAh = 0 (self-test pass), FCh = 1 (self-test fail), FAh = 2 (acknowledge), EEh = 3 (echo), FEh = 4 (resend), 00h or FFh = 5 (overrun).
- R8: A byte that does not fit the sequence in progress is dropped and the state returns to idle. Cases: E0h, F0h or E1h after a break prefix; E0h or E1h after an extended prefix; any byte that breaks a print screen or pause sequence.
- R9: After reset, every output is zero. The code, extended, release and status kind outputs keep their last values between pulses.
- R10: The same make code given in consecutive cycles yields one press event for each byte.
- R11: A key event and a status pulse are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_i | input | BYTE_W | Received byte |
| byte_vld_i | input | 1 | Byte strobe, one cycle per byte |
| evt_vld_o | output | 1 | Key event pulse |
| evt_code_o | output | BYTE_W | Base code of the key |
| evt_ext_o | output | 1 | Key was sent with the E0h prefix |
| evt_rel_o | output | 1 | Event is a release |
| stat_vld_o | output | 1 | Response code pulse |
| stat_kind_o | output | 3 | Response kind, encoded as in R7 |

## Verification
The hardest states to reach are the deep ones inside the print screen break and pause sequences. A byte that departs from the expected sequence there must be dropped without leaving the decoder stuck mid-sequence. The stimulus drives each sequence up to a chosen depth, injects an off-sequence byte, and then sends a plain make code. Exactly one press event for that make code shows that the state returned to idle. Full sweeps over all 256 byte values under each prefix cover every code and response byte.

// File: rtl/kbd_sc2_pkg.sv
package kbd_sc2_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_REL,
      S_EXT,
      S_EXT_REL,
      S_PRT_M1,
      S_PRT_M2,
      S_PRT_B1,
      S_PRT_B2,
      S_PRT_B3,
      S_PAUSE
   } seq_state_e;

   typedef enum logic [2:0] {
      RSP_PASS    = 3'd0,
      RSP_FAIL    = 3'd1,
      RSP_ACK     = 3'd2,
      RSP_ECHO    = 3'd3,
      RSP_RESEND  = 3'd4,
      RSP_OVERRUN = 3'd5
   } rsp_kind_e;

   typedef struct packed {
      logic [7:0] code;
      logic       ext;
      logic       rel;
   } key_evt_t;

   localparam logic [7:0] PFX_EXT   = 8'hE0;
   localparam logic [7:0] PFX_BRK   = 8'hF0;
   localparam logic [7:0] PFX_PAUSE = 8'hE1;
   localparam logic [7:0] PRT_LEAD  = 8'h12;
   localparam logic [7:0] PRT_KEY   = 8'h7C;

   localparam int PAUSE_LEN   = 8;
   localparam int PAUSE_IDX_W = $clog2(PAUSE_LEN);

   // Expected byte at each position of the pause sequence.
   function automatic logic [7:0] pause_byte(input logic [PAUSE_IDX_W-1:0] idx);
      logic [7:0] r;
      case (idx)
         3'd0:    r = 8'hE1;
         3'd1:    r = 8'h14;
         3'd2:    r = 8'h77;
         3'd3:    r = 8'hE1;
         3'd4:    r = 8'hF0;
         3'd5:    r = 8'h14;
         3'd6:    r = 8'hF0;
         default: r = 8'h77;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/kbd_rsp_class.sv
module kbd_rsp_class
   import kbd_sc2_pkg::*;
(
   input  logic [7:0] byte_i,
   output logic       hit_o,
   output rsp_kind_e  kind_o
);
   always_comb begin
      hit_o  = 1'b1;
      kind_o = RSP_PASS;
      case (byte_i)
         8'hAA:        kind_o = RSP_PASS;
         8'hFC:        kind_o = RSP_FAIL;
         8'hFA:        kind_o = RSP_ACK;
         8'hEE:        kind_o = RSP_ECHO;
         8'hFE:        kind_o = RSP_RESEND;
         8'h00, 8'hFF: kind_o = RSP_OVERRUN;
         default:      hit_o  = 1'b0;
      endcase
   end
endmodule

// File: rtl/kbd_pause_match.sv
module kbd_pause_match
   import kbd_sc2_pkg::*;
(
   input  logic [PAUSE_IDX_W-1:0] idx_i,
   input  logic [7:0]             byte_i,
   output logic                   match_o,
   output logic                   last_o
);
   assign match_o = (byte_i == pause_byte(idx_i));
   assign last_o  = (idx_i == PAUSE_IDX_W'(PAUSE_LEN - 1));
endmodule

// File: rtl/kbd_seq_fsm.sv
module kbd_seq_fsm
   import kbd_sc2_pkg::*;
#(
   parameter int PRT_MERGE = 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [7:0]             byte_i,
   input  logic                   vld_i,
   input  logic                   rsp_hit_i,
   input  logic                   pz_match_i,
   input  logic                   pz_last_i,
   output logic [PAUSE_IDX_W-1:0] pz_idx_o,
   output logic                   evt_fire_o,
   output key_evt_t               evt_o,
   output logic                   rsp_fire_o
);
   seq_state_e             st, nxt;
   logic [PAUSE_IDX_W-1:0] idx, nxt_idx;
   logic                   prt_en;
   logic                   is_pfx;

   generate
      if (PRT_MERGE != 0) begin : g_prt_merge
         assign prt_en = 1'b1;
      end else begin : g_prt_plain
         assign prt_en = 1'b0;
      end
   endgenerate

   assign is_pfx   = (byte_i == PFX_EXT) || (byte_i == PFX_BRK) || (byte_i == PFX_PAUSE);
   assign pz_idx_o = idx;

   always_comb begin
      nxt        = st;
      nxt_idx    = idx;
      evt_fire_o = 1'b0;
      evt_o      = '0;
      rsp_fire_o = 1'b0;
      if (vld_i) begin
         case (st)
            S_IDLE: begin
               if (byte_i == PFX_EXT) begin
                  nxt = S_EXT;
               end else if (byte_i == PFX_BRK) begin
                  nxt = S_REL;
               end else if (byte_i == PFX_PAUSE) begin
                  nxt     = S_PAUSE;
                  nxt_idx = PAUSE_IDX_W'(1);
               end else if (rsp_hit_i) begin
                  rsp_fire_o = 1'b1;
               end else begin
                  evt_fire_o = 1'b1;
                  evt_o.code = byte_i;
               end
            end
            S_REL: begin
               nxt = S_IDLE;
               if (!is_pfx) begin
                  evt_fire_o = 1'b1;
                  evt_o.code = byte_i;
                  evt_o.rel  = 1'b1;
               end
            end
            S_EXT: begin
               nxt = S_IDLE;
               if (byte_i == PFX_BRK) begin
                  nxt = S_EXT_REL;
               end else if (prt_en && byte_i == PRT_LEAD) begin
                  nxt = S_PRT_M1;
               end else if (!is_pfx) begin
                  evt_fire_o = 1'b1;
                  evt_o.code = byte_i;
                  evt_o.ext  = 1'b1;
               end
            end
            S_EXT_REL: begin
               nxt = S_IDLE;
               if (prt_en && byte_i == PRT_KEY) begin
                  nxt = S_PRT_B1;
               end else if (!is_pfx) begin
                  evt_fire_o = 1'b1;
                  evt_o.code = byte_i;
                  evt_o.ext  = 1'b1;
                  evt_o.rel  = 1'b1;
               end
            end
            S_PRT_M1: nxt = (byte_i == PFX_EXT) ? S_PRT_M2 : S_IDLE;
            S_PRT_M2: begin
               nxt = S_IDLE;
               if (byte_i == PRT_KEY) begin
                  evt_fire_o = 1'b1;
                  evt_o.code = PRT_KEY;
                  evt_o.ext  = 1'b1;
               end
            end
            S_PRT_B1: nxt = (byte_i == PFX_EXT) ? S_PRT_B2 : S_IDLE;
            S_PRT_B2: nxt = (byte_i == PFX_BRK) ? S_PRT_B3 : S_IDLE;
            S_PRT_B3: begin
               nxt = S_IDLE;
               if (byte_i == PRT_LEAD) begin
                  evt_fire_o = 1'b1;
                  evt_o.code = PRT_KEY;
                  evt_o.ext  = 1'b1;
                  evt_o.rel  = 1'b1;
               end
            end
            S_PAUSE: begin
               if (!pz_match_i) begin
                  nxt = S_IDLE;
               end else if (pz_last_i) begin
                  nxt        = S_IDLE;
                  evt_fire_o = 1'b1;
                  evt_o.code = PFX_PAUSE;
               end else begin
                  nxt_idx = idx + 1'b1;
               end
            end
            default: nxt = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= S_IDLE;
         idx <= '0;
      end else begin
         st  <= nxt;
         idx <= nxt_idx;
      end
   end
endmodule

// File: rtl/kbd_evt_out.sv
module kbd_evt_out
   import kbd_sc2_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt_fire_i,
   input  key_evt_t   evt_i,
   input  logic       rsp_fire_i,
   input  rsp_kind_e  rsp_kind_i,
   output logic       evt_vld_o,
   output key_evt_t   evt_o,
   output logic       stat_vld_o,
   output logic [2:0] stat_kind_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_vld_o   <= 1'b0;
         evt_o       <= '0;
         stat_vld_o  <= 1'b0;
         stat_kind_o <= '0;
      end else begin
         evt_vld_o  <= evt_fire_i;
         stat_vld_o <= rsp_fire_i;
         if (evt_fire_i) evt_o       <= evt_i;
         if (rsp_fire_i) stat_kind_o <= rsp_kind_i;
      end
   end
endmodule

// File: rtl/kbd_sc2_decoder.sv
module kbd_sc2_decoder
   import kbd_sc2_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int PRT_MERGE = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              byte_vld_i,
   output logic              evt_vld_o,
   output logic [BYTE_W-1:0] evt_code_o,
   output logic              evt_ext_o,
   output logic              evt_rel_o,
   output logic              stat_vld_o,
   output logic [2:0]        stat_kind_o
);
   generate
      if (BYTE_W != 8) begin : g_bad_width
         initial $fatal(1, "kbd_sc2_decoder: BYTE_W must be 8");
      end
      if (PRT_MERGE != 0 && PRT_MERGE != 1) begin : g_bad_prt
         initial $fatal(1, "kbd_sc2_decoder: PRT_MERGE must be 0 or 1");
      end
   endgenerate

   logic                   rsp_hit;
   rsp_kind_e              rsp_kind;
   logic                   pz_match, pz_last;
   logic [PAUSE_IDX_W-1:0] pz_idx;
   logic                   evt_fire, rsp_fire;
   key_evt_t               evt_nxt, evt_q;

   kbd_rsp_class i_rsp (
      .byte_i (byte_i),
      .hit_o  (rsp_hit),
      .kind_o (rsp_kind)
   );

   kbd_pause_match i_pz (
      .idx_i   (pz_idx),
      .byte_i  (byte_i),
      .match_o (pz_match),
      .last_o  (pz_last)
   );

   kbd_seq_fsm #(.PRT_MERGE(PRT_MERGE)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_i     (byte_i),
      .vld_i      (byte_vld_i),
      .rsp_hit_i  (rsp_hit),
      .pz_match_i (pz_match),
      .pz_last_i  (pz_last),
      .pz_idx_o   (pz_idx),
      .evt_fire_o (evt_fire),
      .evt_o      (evt_nxt),
      .rsp_fire_o (rsp_fire)
   );

   kbd_evt_out i_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_fire_i  (evt_fire),
      .evt_i       (evt_nxt),
      .rsp_fire_i  (rsp_fire),
      .rsp_kind_i  (rsp_kind),
      .evt_vld_o   (evt_vld_o),
      .evt_o       (evt_q),
      .stat_vld_o  (stat_vld_o),
      .stat_kind_o (stat_kind_o)
   );

   assign evt_code_o = evt_q.code;
   assign evt_ext_o  = evt_q.ext;
   assign evt_rel_o  = evt_q.rel;
endmodule

// File: rtl/kbd_sc2_checker.sv
module kbd_sc2_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] byte_i,
   input logic       byte_vld_i,
   input logic       evt_vld_o,
   input logic [7:0] evt_code_o,
   input logic       evt_ext_o,
   input logic       evt_rel_o,
   input logic       stat_vld_o,
   input logic [2:0] stat_kind_o
);
   AST_EVT_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vld_o |-> $past(byte_vld_i)); // R1

   AST_CODE_NOT_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vld_o |-> (evt_code_o != 8'hE0 && evt_code_o != 8'hF0)); // R2

   AST_PAUSE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld_o && evt_code_o == 8'hE1) |-> (!evt_rel_o && !evt_ext_o)); // R6

   AST_PAUSE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld_o && evt_code_o == 8'hE1) |-> ($past(byte_i) == 8'h77)); // R6

   AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld_o |-> ($past(byte_vld_i) &&
                      $past(byte_i) inside {8'hAA, 8'hFC, 8'hFA, 8'hEE, 8'hFE, 8'h00, 8'hFF})); // R7

   AST_KIND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld_o |-> (stat_kind_o <= 3'd5)); // R7

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_vld_o |-> ($stable(evt_code_o) && $stable(evt_ext_o) && $stable(evt_rel_o))); // R9

   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_vld_o && stat_vld_o)); // R11
endmodule

bind kbd_sc2_decoder kbd_sc2_checker i_chk (.*);

// File: tb/test_kbd_sc2_decoder.sv
module test_kbd_sc2_decoder;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] byte_i = '0;
   logic       byte_vld_i = 1'b0;
   logic       evt_vld_o, evt_ext_o, evt_rel_o, stat_vld_o;
   logic [7:0] evt_code_o;
   logic [2:0] stat_kind_o;

   int n_chk = 0, n_bad = 0;
   int ev_tot = 0, st_tot = 0, both_tot = 0;
   int ev0 = 0, st0 = 0;
   logic [7:0] l_code = '0;
   logic       l_ext = 1'b0, l_rel = 1'b0;
   logic [2:0] l_kind = '0;
   logic       done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   kbd_sc2_decoder i_kbd_sc2_decoder (
      .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .byte_vld_i(byte_vld_i),
      .evt_vld_o(evt_vld_o), .evt_code_o(evt_code_o), .evt_ext_o(evt_ext_o),
      .evt_rel_o(evt_rel_o), .stat_vld_o(stat_vld_o), .stat_kind_o(stat_kind_o)
   );

   always @(negedge clk) begin
      if (evt_vld_o) begin
         ev_tot++;
         l_code = evt_code_o; l_ext = evt_ext_o; l_rel = evt_rel_o;
      end
      if (stat_vld_o) begin
         st_tot++;
         l_kind = stat_kind_o;
      end
      if (evt_vld_o && stat_vld_o) both_tot++;
   end

   function automatic bit is_rsp(input logic [7:0] b);
      return b inside {8'hAA, 8'hFC, 8'hFA, 8'hEE, 8'hFE, 8'h00, 8'hFF};
   endfunction

   function automatic logic [2:0] rsp_kind(input logic [7:0] b);
      case (b)
         8'hAA:   return 3'd0;
         8'hFC:   return 3'd1;
         8'hFA:   return 3'd2;
         8'hEE:   return 3'd3;
         8'hFE:   return 3'd4;
         default: return 3'd5;
      endcase
   endfunction

   function automatic bit is_pfx(input logic [7:0] b);
      return b == 8'hE0 || b == 8'hF0 || b == 8'hE1;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      byte_i = b; byte_vld_i = 1'b1;
      @(negedge clk);
      byte_vld_i = 1'b0;
   endtask

   task automatic snap();
      ev0 = ev_tot; st0 = st_tot;
   endtask

   task automatic expect_evt(input string req, input logic [7:0] c, input logic e, input logic r);
      logic [31:0] act, exp;
      repeat (2) @(negedge clk);
      act = {4'(ev_tot - ev0), 4'(st_tot - st0), 6'd0, l_code, 8'd0, 1'b0, l_ext, 1'b0, l_rel};
      exp = {4'd1, 4'd0, 6'd0, c, 8'd0, 1'b0, e, 1'b0, r};
      check(act == exp, req, act, exp);
   endtask

   task automatic expect_stat(input string req, input logic [2:0] k);
      logic [31:0] act, exp;
      repeat (2) @(negedge clk);
      act = {4'(ev_tot - ev0), 4'(st_tot - st0), 21'd0, l_kind};
      exp = {4'd0, 4'd1, 21'd0, k};
      check(act == exp, req, act, exp);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check({evt_vld_o, evt_code_o, evt_ext_o, evt_rel_o, stat_vld_o, stat_kind_o} == '0,
            "R9 reset", {evt_vld_o, evt_code_o, evt_ext_o, evt_rel_o, stat_vld_o, stat_kind_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 / R7 idle sweep
      for (int c = 0; c < 256; c++) begin
         if (is_pfx(8'(c))) continue;
         snap(); put(8'(c));
         if (is_rsp(8'(c))) expect_stat("R7 status", rsp_kind(8'(c)));
         else expect_evt("R1 make", 8'(c), 1'b0, 1'b0);
      end

      // R2 release sweep
      for (int c = 0; c < 256; c++) begin
         if (is_pfx(8'(c))) continue;
         snap(); put(8'hF0); put(8'(c));
         expect_evt("R2 release", 8'(c), 1'b0, 1'b1);
      end

      // R3 extended press and release sweeps
      for (int c = 0; c < 256; c++) begin
         if (is_pfx(8'(c)) || c == 8'h12) continue;
         snap(); put(8'hE0); put(8'(c));
         expect_evt("R3 ext make", 8'(c), 1'b1, 1'b0);
      end
      for (int c = 0; c < 256; c++) begin
         if (is_pfx(8'(c)) || c == 8'h7C) continue;
         snap(); put(8'hE0); put(8'hF0); put(8'(c));
         expect_evt("R3 ext release", 8'(c), 1'b1, 1'b1);
      end

      // R4 / R5 print screen
      snap(); put(8'hE0); put(8'h12); put(8'hE0); put(8'h7C);
      expect_evt("R4 prtscr make", 8'h7C, 1'b1, 1'b0);
      snap(); put(8'hE0); put(8'hF0); put(8'h7C); put(8'hE0); put(8'hF0); put(8'h12);
      expect_evt("R5 prtscr break", 8'h7C, 1'b1, 1'b1);

      // R6 pause
      snap();
      put(8'hE1); put(8'h14); put(8'h77); put(8'hE1);
      put(8'hF0); put(8'h14); put(8'hF0); put(8'h77);
      expect_evt("R6 pause", 8'hE1, 1'b0, 1'b0);

      // R8 off-sequence bytes dropped, next byte decoded from idle
      snap(); put(8'hF0); put(8'hE0); put(8'h1C);
      expect_evt("R8 F0 then E0", 8'h1C, 1'b0, 1'b0);
      snap(); put(8'hE0); put(8'hE1); put(8'h1C);
      expect_evt("R8 E0 then E1", 8'h1C, 1'b0, 1'b0);
      snap(); put(8'hE0); put(8'h12); put(8'h55); put(8'h1C);
      expect_evt("R8 prtscr make cut", 8'h1C, 1'b0, 1'b0);
      snap(); put(8'hE0); put(8'hF0); put(8'h7C); put(8'hE0); put(8'h33); put(8'h1C);
      expect_evt("R8 prtscr break cut", 8'h1C, 1'b0, 1'b0);
      snap(); put(8'hE0); put(8'hF0); put(8'h7C); put(8'hE0); put(8'hF0); put(8'h33); put(8'h1C);
      expect_evt("R8 prtscr break tail", 8'h1C, 1'b0, 1'b0);
      for (int d = 1; d < 8; d++) begin
         logic [7:0] seq [8] = '{8'hE1, 8'h14, 8'h77, 8'hE1, 8'hF0, 8'h14, 8'hF0, 8'h77};
         snap();
         for (int k = 0; k < d; k++) put(seq[k]);
         put(8'h5A); put(8'h1C);
         expect_evt("R8 pause cut", 8'h1C, 1'b0, 1'b0);
      end

      // R10 back-to-back repeats
      snap();
      @(negedge clk); byte_i = 8'h2B; byte_vld_i = 1'b1;
      repeat (3) @(negedge clk);
      byte_vld_i = 1'b0;
      repeat (2) @(negedge clk);
      check(ev_tot - ev0 == 3 && l_code == 8'h2B, "R10 repeat", 32'(ev_tot - ev0), 3);

      // R9 hold between pulses
      snap(); put(8'hE0); put(8'h75);
      repeat (6) @(negedge clk);
      check({evt_code_o, evt_ext_o, evt_rel_o} == {8'h75, 1'b1, 1'b0}, "R9 hold",
            {evt_code_o, evt_ext_o, evt_rel_o}, {8'h75, 1'b1, 1'b0});
      check(stat_kind_o == 3'd5, "R9 kind hold", stat_kind_o, 3'd5);

      // R11 never both channels valid
      check(both_tot == 0, "R11 exclusive", both_tot, 0);

      done = 1'b1;
      finish_run();
   end
endmodule